// File: doc/BRIEF.md
# Two-Wire Serial Interface Control Register

This block holds the software-visible control word of a two-wire serial (I2C) controller. Software sets and clears six control bits through a simple register write and read port. The protocol engine next to it reports bus events as level flags and the current role (master or slave). From these flags the register clears some of its own bits, drives the SCL-hold request and the request to release the lines in slave mode, and raises a registered interrupt.

The six bits are: interface enable, general-call enable, start request, acknowledge enable, stop request and interrupt enable. Each bit has its own hardware clear rule. Start request, acknowledge enable and interrupt enable are forced low while the interface is disabled. General-call enable and stop request keep their value when the interface is disabled. Start request clears when the engine reports that a start was sent. Stop request clears on the stop-sent flag, but only in master mode. In slave mode, a set stop request asks the engine to let go of both lines once a byte transfer has finished.

Top module: `i2c_ctl_reg`

## Requirements
- R1: After reset the control word is 0x0000. Bits 15..6 always read as zero, even after a write of ones.
- R2: A write lands on the next rising clock edge. `rdata` shows the control word in the same cycle that `rd_en` is high, and is zero while `rd_en` is low.
- R3: While the enable bit (bit 5) is 0, the start request (bit 3), acknowledge enable (bit 2) and interrupt enable (bit 0) are cleared one edge later. A write that tries to set them while the interface is disabled leaves them at 0.
- R4: General-call enable (bit 4) and stop request (bit 1) are changed only by writes. Disabling the interface does not clear them.
- R5: The start-sent flag clears the start request on the next edge. This clear wins over a write that sets bit 3 in the same cycle.
- R6: In master mode (`master_mode`=1) the stop-sent flag clears the stop request on the next edge. In slave mode the stop request stays set until software clears it.
- R7: `release_lines` is 1 exactly when the block is in slave mode, the stop request is set and `byte_done` is 1.
- R8: `scl_hold` is 1 while the interface is enabled and any of `hdr10_flag`, `start_sent`, `byte_done`, `addr_match` or `addr_done` is 1. It is 0 while the interface is disabled.
- R9: `irq` goes to 1 one edge after any of the five event flags is seen with interrupt enable set. It stays 1 while the flag stays high and falls one edge after the flag clears. It is 0 while interrupt enable is 0.
- R10: A write that sets the enable bit while the interface is disabled sets the enable bit. Bits 3, 2 and 0 from that same write stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, zero when not reading |
| ctrl_q | output | 16 | Current control word |
| master_mode | input | 1 | 1 = master role, 0 = slave role |
| hdr10_flag | input | 1 | 10-bit address header phase flag |
| start_sent | input | 1 | Start condition sent flag |
| byte_done | input | 1 | Byte transfer finished flag |
| addr_match | input | 1 | Own address matched flag |
| addr_done | input | 1 | Address phase completed flag |
| stop_sent | input | 1 | Stop condition sent flag |
| release_lines | output | 1 | Release SCL and SDA (slave stop) |
| scl_hold | output | 1 | Hold SCL low request |
| irq | output | 1 | Interrupt request |

## Verification
Any wrong bit in the stored control word shows on `ctrl_q` at the next sample after the edge that loaded it. If that bit feeds an output, the error also appears on `release_lines` or `scl_hold` in the same cycle, and on `irq` one edge later. A wrong clear rule (a bit that survives disable, or a stop request cleared in slave mode) therefore becomes visible within two clock edges of the triggering flag or write. The directed scenarios sample at exactly those points.

// File: rtl/i2c_ctl_pkg.sv
// Package: shared field layout of the serial-interface control word.
// Assumes the six control fields sit in the low bits. Software decodes
// these bit positions, so the order is fixed.
package i2c_ctl_pkg;

    localparam int unsigned FLD_N   = 6;
    localparam int unsigned B_IRQEN = 0;
    localparam int unsigned B_STOP  = 1;
    localparam int unsigned B_ACK   = 2;
    localparam int unsigned B_START = 3;
    localparam int unsigned B_GCALL = 4;
    localparam int unsigned B_EN    = 5;

    // Packed from bit 5 down to bit 0.
    typedef struct packed {
        logic en;
        logic gcall;
        logic start_req;
        logic ack_en;
        logic stop_req;
        logic irq_en;
    } ctl_t;

endpackage

// File: rtl/i2c_ctl_bits.sv
// Module: storage of the six control fields with their clear rules.
// Assumes the event flags are levels that are already synchronous to clk.
// A hardware clear always wins over a software write to the same bit.
// The enable bit itself is only ever written by software.
module i2c_ctl_bits
    import i2c_ctl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  ctl_t wr_fld,
    input  logic master_mode,
    input  logic start_sent,
    input  logic stop_sent,
    output ctl_t q
);

    ctl_t d;

    // Next state: the software write first, then the hardware clears on top.
    always_comb begin
        d = q;
        if (wr_en) begin
            d = wr_fld;
        end
        if (!q.en) begin
            d.start_req = 1'b0;
            d.ack_en    = 1'b0;
            d.irq_en    = 1'b0;
        end
        if (start_sent) begin
            d.start_req = 1'b0;
        end
        if (master_mode && stop_sent) begin
            d.stop_req = 1'b0;
        end
    end

    // Register update with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/i2c_ctl_lines.sv
// Module: combinational line-control requests toward the protocol engine.
// Assumes hold_flags holds every event that must stretch SCL.
module i2c_ctl_lines #(
    parameter int unsigned N_HOLD = 5
) (
    input  logic              en,
    input  logic              master_mode,
    input  logic              stop_req,
    input  logic              byte_done,
    input  logic [N_HOLD-1:0] hold_flags,
    output logic              scl_hold,
    output logic              release_lines
);

    // Stretch SCL while enabled and any hold event is pending.
    always_comb begin
        scl_hold = en && (|hold_flags);
    end

    // In slave mode, a stop request lets go of both lines after the byte.
    always_comb begin
        release_lines = !master_mode && stop_req && byte_done;
    end

endmodule

// File: rtl/i2c_ctl_irq.sv
// Module: registered interrupt request from the level event flags.
// Assumes each source stays high until the engine clears it, so the
// request stays high for exactly as long as its cause.
module i2c_ctl_irq #(
    parameter int unsigned N_SRC = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             irq_en,
    input  logic [N_SRC-1:0] src,
    output logic             irq
);

    // Register the gated OR of all sources.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq <= 1'b0;
        end else begin
            irq <= irq_en && (|src);
        end
    end

endmodule

// File: rtl/i2c_ctl_reg.sv
// Module: top of the serial-interface control register.
// Assumes REG_W >= 6. Bits above the six fields always read as zero.
// A read returns the word in the same cycle; a write lands on the next edge.
module i2c_ctl_reg
    import i2c_ctl_pkg::*;
#(
    parameter int unsigned REG_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] rdata,
    output logic [REG_W-1:0] ctrl_q,
    input  logic             master_mode,
    input  logic             hdr10_flag,
    input  logic             start_sent,
    input  logic             byte_done,
    input  logic             addr_match,
    input  logic             addr_done,
    input  logic             stop_sent,
    output logic             release_lines,
    output logic             scl_hold,
    output logic             irq
);

    localparam int unsigned N_EVT = 5;

    ctl_t             fld_q;
    ctl_t             wr_fld;
    logic [N_EVT-1:0] evt;

    // Pick the field bits out of the write data.
    always_comb begin
        wr_fld = ctl_t'(wdata[FLD_N-1:0]);
    end

    // Gather the events that stretch SCL and request an interrupt.
    always_comb begin
        evt = {addr_done, addr_match, byte_done, start_sent, hdr10_flag};
    end

    i2c_ctl_bits u_bits (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_fld      (wr_fld),
        .master_mode (master_mode),
        .start_sent  (start_sent),
        .stop_sent   (stop_sent),
        .q           (fld_q)
    );

    i2c_ctl_lines #(.N_HOLD(N_EVT)) u_lines (
        .en            (fld_q.en),
        .master_mode   (master_mode),
        .stop_req      (fld_q.stop_req),
        .byte_done     (byte_done),
        .hold_flags    (evt),
        .scl_hold      (scl_hold),
        .release_lines (release_lines)
    );

    i2c_ctl_irq #(.N_SRC(N_EVT)) u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .irq_en (fld_q.irq_en),
        .src    (evt),
        .irq    (irq)
    );

    // Build the full word: the fields at the bottom, zeros above them.
    generate
        if (REG_W > FLD_N) begin : g_pad
            always_comb begin
                ctrl_q = {{(REG_W-FLD_N){1'b0}}, fld_q};
            end
        end else begin : g_nopad
            always_comb begin
                ctrl_q = fld_q;
            end
        end
    endgenerate

    // The read port shows the word only while the strobe is high.
    always_comb begin
        rdata = rd_en ? ctrl_q : '0;
    end

endmodule

// File: rtl/i2c_ctl_reg_chk.sv
// Module: property checker bound to the control register top.
// Assumes the field positions from i2c_ctl_pkg.
module i2c_ctl_reg_chk #(
    parameter int unsigned REG_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic             rd_en,
    input logic [REG_W-1:0] wdata,
    input logic [REG_W-1:0] rdata,
    input logic [REG_W-1:0] ctrl_q,
    input logic             master_mode,
    input logic             hdr10_flag,
    input logic             start_sent,
    input logic             byte_done,
    input logic             addr_match,
    input logic             addr_done,
    input logic             stop_sent,
    input logic             irq
);

    logic any_evt;
    assign any_evt = hdr10_flag | start_sent | byte_done | addr_match | addr_done;

    p_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> rdata == ctrl_q);

    p_idle_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |-> rdata == '0);

    p_disabled_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_q[5] |=> (!ctrl_q[3] && !ctrl_q[2] && !ctrl_q[0]));

    p_gcall_sw_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ctrl_q[4] == $past(wdata[4]));

    p_gcall_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(ctrl_q[4]));

    p_start_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        start_sent |=> !ctrl_q[3]);

    p_stop_master_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (master_mode && stop_sent) |=> !ctrl_q[1]);

    p_stop_slave_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!master_mode && !wr_en) |=> $stable(ctrl_q[1]));

    p_irq_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q[0] && any_evt) |=> irq);

    p_irq_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_q[0] |=> !irq);

endmodule

bind i2c_ctl_reg i2c_ctl_reg_chk #(.REG_W(REG_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .rd_en       (rd_en),
    .wdata       (wdata),
    .rdata       (rdata),
    .ctrl_q      (ctrl_q),
    .master_mode (master_mode),
    .hdr10_flag  (hdr10_flag),
    .start_sent  (start_sent),
    .byte_done   (byte_done),
    .addr_match  (addr_match),
    .addr_done   (addr_done),
    .stop_sent   (stop_sent),
    .irq         (irq)
);

// File: tb/sim_i2c_ctl_reg.sv
// Directed bench for the control register: one task per scenario.
module sim_i2c_ctl_reg;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic [15:0] ctrl_q;
    logic        master_mode = 1'b1;
    logic [4:0]  evt = '0;
    logic        stop_sent = 1'b0;
    logic        release_lines;
    logic        scl_hold;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    i2c_ctl_reg u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_en         (wr_en),
        .rd_en         (rd_en),
        .wdata         (wdata),
        .rdata         (rdata),
        .ctrl_q        (ctrl_q),
        .master_mode   (master_mode),
        .hdr10_flag    (evt[0]),
        .start_sent    (evt[1]),
        .byte_done     (evt[2]),
        .addr_match    (evt[3]),
        .addr_done     (evt[4]),
        .stop_sent     (stop_sent),
        .release_lines (release_lines),
        .scl_hold      (scl_hold),
        .irq           (irq)
    );

    task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [15:0] d);
        wr_en = 1'b1;
        wdata = d;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 reset word", ctrl_q, 16'h0000);
        chk("R1 reset irq", {15'd0, irq}, 16'd0);
        chk("R8 reset hold", {15'd0, scl_hold}, 16'd0);
    endtask

    task automatic t_enable_rw();
        wr(16'hFFFF);
        chk("R10 enable write", ctrl_q, 16'h0032);
        rd_en = 1'b1;
        #1;
        chk("R2 same-cycle read", rdata, 16'h0032);
        rd_en = 1'b0;
        #1;
        chk("R2 idle read", rdata, 16'h0000);
        @(negedge clk);
        wr(16'hFFFF);
        chk("R1 upper zero", ctrl_q, 16'h003F);
    endtask

    task automatic t_disable();
        wr(16'h0016);
        chk("R3 one edge after disable", ctrl_q, 16'h0016);
        tick();
        chk("R3 R4 cleared after disable", ctrl_q, 16'h0012);
        wr(16'h001F);
        chk("R3 set while disabled", ctrl_q, 16'h0012);
    endtask

    task automatic t_start();
        wr(16'h0020);
        wr(16'h0028);
        chk("R5 start set", ctrl_q, 16'h0028);
        evt[1] = 1'b1;
        tick();
        evt[1] = 1'b0;
        chk("R5 start cleared", ctrl_q, 16'h0020);
        evt[1] = 1'b1;
        wr(16'h0028);
        evt[1] = 1'b0;
        chk("R5 clear beats write", ctrl_q, 16'h0020);
    endtask

    task automatic t_stop();
        master_mode = 1'b1;
        wr(16'h0022);
        stop_sent = 1'b1;
        tick();
        stop_sent = 1'b0;
        chk("R6 master stop cleared", ctrl_q, 16'h0020);
        master_mode = 1'b0;
        wr(16'h0022);
        stop_sent = 1'b1;
        tick();
        tick();
        stop_sent = 1'b0;
        chk("R6 slave stop kept", ctrl_q, 16'h0022);
    endtask

    task automatic t_release();
        master_mode = 1'b0;
        evt[2] = 1'b1;
        #1;
        chk("R7 release slave", {15'd0, release_lines}, 16'd1);
        master_mode = 1'b1;
        #1;
        chk("R7 no release master", {15'd0, release_lines}, 16'd0);
        master_mode = 1'b0;
        evt[2] = 1'b0;
        #1;
        chk("R7 no release before byte", {15'd0, release_lines}, 16'd0);
        @(negedge clk);
        wr(16'h0020);
        master_mode = 1'b1;
    endtask

    task automatic t_hold();
        for (int i = 0; i < 5; i++) begin
            evt = 5'd1 << i;
            #1;
            chk("R8 hold per flag", {15'd0, scl_hold}, 16'd1);
        end
        evt = '0;
        #1;
        chk("R8 no flag", {15'd0, scl_hold}, 16'd0);
        @(negedge clk);
        wr(16'h0000);
        evt = 5'b01000;
        #1;
        chk("R8 disabled no hold", {15'd0, scl_hold}, 16'd0);
        @(negedge clk);
        evt = '0;
    endtask

    task automatic t_irq();
        wr(16'h0020);
        evt[3] = 1'b1;
        tick();
        chk("R9 gated off", {15'd0, irq}, 16'd0);
        evt[3] = 1'b0;
        wr(16'h0021);
        evt[3] = 1'b1;
        #1;
        chk("R9 not yet", {15'd0, irq}, 16'd0);
        @(negedge clk);
        tick();
        chk("R9 raised", {15'd0, irq}, 16'd1);
        tick();
        chk("R9 held", {15'd0, irq}, 16'd1);
        evt[3] = 1'b0;
        tick();
        chk("R9 dropped", {15'd0, irq}, 16'd0);
    endtask

    initial begin
        #(200000 * 4);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        tick();
        tick();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_enable_rw();
        t_disable();
        t_start();
        t_stop();
        t_release();
        t_hold();
        t_irq();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule